// File: doc/BRIEF.md
# Effective address generator

This block forms the memory address for a load-store processor in a single registered stage. Decode hands it a mode code, the operand size and the values it needs: the addressed register Rn, the index register R0, the global base register, the program counter and the raw displacement field from the instruction word. One clock later it presents the effective address, a flag saying whether the result is a data-memory access, and, for the auto-modifying modes, the new value of Rn with a write-back strobe for the register file.

Displacements are zero-extended and multiplied by the access size (1, 2 or 4 bytes) before the add. Stack-style push uses the pre-decrement mode and pop or array walks use post-increment. Constant loads use the PC-relative literal mode, which aligns the PC down to a longword boundary for longword accesses. One extra mode computes a signed, halfword-scaled branch target from the PC. Register-direct and immediate modes pass through without an address.

Top module: `eagen_top`

## Requirements
- R1: While `rst` is high at a rising clock edge, every output is driven to zero on that edge, whatever the inputs.
- R2: Outputs change one clock after `in_valid` is sampled. A cycle with `in_valid` low gives `out_valid`, `mem_access` and `rn_wb_en` low, and `ea` and `rn_wb_val` keep their previous values.
- R3: Mode 2 (register indirect) gives `ea` = Rn with `mem_access` high.
- R4: Mode 3 (post-increment) gives `ea` = Rn and `rn_wb_val` = Rn + step, where the step is 1, 2 or 4 for size codes 0, 1 and 2 (code 3 counts as 4). All sums wrap modulo 2^32.
- R5: Mode 4 (pre-decrement) gives `ea` = `rn_wb_val` = Rn − step, with the same step and wrap as R4.
- R6: Mode 5 gives `ea` = Rn + zero-extended `disp[3:0]` shifted left by 0, 1 or 2 for size codes 0, 1 and 2 (code 3 shifts by 2).
- R7: Mode 6 gives `ea` = R0 + Rn. Mode 8 gives `ea` = R0 + GBR.
- R8: Mode 7 gives `ea` = GBR + zero-extended `disp[7:0]` scaled by size as in R6.
- R9: Mode 9 (PC literal) gives `ea` = base + zero-extended `disp[7:0]` scaled by size. The base is the PC with bits [1:0] cleared for size codes 2 and 3, and the unchanged PC otherwise.
- R10: Mode 10 gives `ea` = PC + sign-extended `disp[11:0]` × 2, with `mem_access` low.
- R11: `rn_wb_en` is high only after modes 3 and 4. Otherwise `rn_wb_val` = Rn. `mem_access` is high for modes 2 to 9 only. Modes 0 (register direct), 1 (immediate) and 11 to 15 (reserved) give `ea` = 0 and `mem_access` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request present this cycle |
| mode_i | input | 4 | Addressing mode code |
| size_i | input | 2 | Operand size: 0 byte, 1 word, 2/3 longword |
| rn_i | input | 32 | Value of register Rn |
| r0_i | input | 32 | Value of index register R0 |
| gbr_i | input | 32 | Global base register |
| pc_i | input | 32 | Program counter used for relative modes |
| disp_i | input | 12 | Raw displacement field |
| out_valid | output | 1 | Result valid |
| ea_o | output | 32 | Effective address or branch target |
| mem_access_o | output | 1 | Result addresses data memory |
| rn_wb_en_o | output | 1 | Write `rn_wb_val_o` back to Rn |
| rn_wb_val_o | output | 32 | New value for Rn |

## Verification
The bench aims at wraparound at both ends of the address space. Pre-decrement from zero must give 0xFFFFFFFC or 0xFFFFFFFF, and post-increment from the top must give zero. A design with a wrong carry width would show a stray high bit there. It runs the PC-literal mode with a PC whose low bits are set, under every size: a design that aligns for words or forgets to align longwords gives an address off by up to 3. It also uses all-ones displacements to catch truncation or sign extension where zero extension is due, and negative 12-bit branch offsets to catch the opposite. Idle cycles between requests check that no write-back strobe leaks out and that the held address does not change.

// File: rtl/eagen_pkg.sv
package eagen_pkg;
  typedef enum logic [3:0] {
    AM_DIRECT  = 4'd0,
    AM_IMM     = 4'd1,
    AM_IND     = 4'd2,
    AM_POSTINC = 4'd3,
    AM_PREDEC  = 4'd4,
    AM_DISP4   = 4'd5,
    AM_IDX_RN  = 4'd6,
    AM_GBR_D8  = 4'd7,
    AM_IDX_GBR = 4'd8,
    AM_PC_LIT  = 4'd9,
    AM_PC_BR   = 4'd10
  } amode_e;

  typedef enum logic [1:0] {
    SZ_BYTE  = 2'd0,
    SZ_WORD  = 2'd1,
    SZ_LONG  = 2'd2,
    SZ_LONGX = 2'd3
  } osize_e;

  function automatic logic [1:0] size_shift(input logic [1:0] sz);
    case (sz)
      2'd0:    return 2'd0;
      2'd1:    return 2'd1;
      default: return 2'd2;
    endcase
  endfunction
endpackage

// File: rtl/eagen_scale.sv
module eagen_scale #(
  parameter int IN_W  = 4,
  parameter int OUT_W = 32
) (
  input  logic [IN_W-1:0]  d_i,
  input  logic [1:0]       size_i,
  output logic [OUT_W-1:0] q_o
);
  import eagen_pkg::*;

  localparam int PAD_W = OUT_W - IN_W;

  logic [OUT_W-1:0] zext;
  assign zext = {{PAD_W{1'b0}}, d_i};

  always_comb begin
    case (size_shift(size_i))
      2'd0:    q_o = zext;
      2'd1:    q_o = zext << 1;
      default: q_o = zext << 2;
    endcase
  end
endmodule

// File: rtl/eagen_step.sv
module eagen_step #(
  parameter int AW = 32
) (
  input  logic [1:0]    size_i,
  output logic [AW-1:0] step_o
);
  import eagen_pkg::*;

  localparam logic [AW-1:0] ONE = AW'(1);

  assign step_o = ONE << size_shift(size_i);
endmodule

// File: rtl/eagen_calc.sv
module eagen_calc #(
  parameter int AW   = 32,
  parameter int DW   = 12,
  parameter int D4_W = 4,
  parameter int D8_W = 8
) (
  input  logic [3:0]    mode_i,
  input  logic [1:0]    size_i,
  input  logic [AW-1:0] rn_i,
  input  logic [AW-1:0] r0_i,
  input  logic [AW-1:0] gbr_i,
  input  logic [AW-1:0] pc_i,
  input  logic [DW-1:0] disp_i,
  output logic [AW-1:0] ea_o,
  output logic          mem_o,
  output logic          wb_en_o,
  output logic [AW-1:0] wb_val_o
);
  import eagen_pkg::*;

  localparam int BR_PAD = AW - DW - 1;

  logic [AW-1:0] step;
  logic [AW-1:0] d4_scaled;
  logic [AW-1:0] d8_scaled;
  logic [AW-1:0] br_off;
  logic [AW-1:0] pc_base;
  logic [AW-1:0] rn_dec;
  logic          long_acc;
  amode_e        am;

  eagen_step #(.AW(AW)) u_step (
    .size_i (size_i),
    .step_o (step)
  );

  eagen_scale #(.IN_W(D4_W), .OUT_W(AW)) u_sc4 (
    .d_i    (disp_i[D4_W-1:0]),
    .size_i (size_i),
    .q_o    (d4_scaled)
  );

  eagen_scale #(.IN_W(D8_W), .OUT_W(AW)) u_sc8 (
    .d_i    (disp_i[D8_W-1:0]),
    .size_i (size_i),
    .q_o    (d8_scaled)
  );

  assign am       = amode_e'(mode_i);
  assign long_acc = size_i[1];
  assign br_off   = {{BR_PAD{disp_i[DW-1]}}, disp_i, 1'b0};
  assign pc_base  = long_acc ? {pc_i[AW-1:2], 2'b00} : pc_i;
  assign rn_dec   = rn_i - step;

  always_comb begin
    ea_o     = '0;
    mem_o    = 1'b0;
    wb_en_o  = 1'b0;
    wb_val_o = rn_i;
    case (am)
      AM_IND: begin
        ea_o  = rn_i;
        mem_o = 1'b1;
      end
      AM_POSTINC: begin
        ea_o     = rn_i;
        mem_o    = 1'b1;
        wb_en_o  = 1'b1;
        wb_val_o = rn_i + step;
      end
      AM_PREDEC: begin
        ea_o     = rn_dec;
        mem_o    = 1'b1;
        wb_en_o  = 1'b1;
        wb_val_o = rn_dec;
      end
      AM_DISP4: begin
        ea_o  = rn_i + d4_scaled;
        mem_o = 1'b1;
      end
      AM_IDX_RN: begin
        ea_o  = r0_i + rn_i;
        mem_o = 1'b1;
      end
      AM_GBR_D8: begin
        ea_o  = gbr_i + d8_scaled;
        mem_o = 1'b1;
      end
      AM_IDX_GBR: begin
        ea_o  = r0_i + gbr_i;
        mem_o = 1'b1;
      end
      AM_PC_LIT: begin
        ea_o  = pc_base + d8_scaled;
        mem_o = 1'b1;
      end
      AM_PC_BR: begin
        ea_o = pc_i + br_off;
      end
      default: begin
        ea_o = '0;
      end
    endcase
  end
endmodule

// File: rtl/eagen_top.sv
module eagen_top #(
  parameter int AW   = 32,
  parameter int DW   = 12,
  parameter int D4_W = 4,
  parameter int D8_W = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  input  logic [3:0]    mode_i,
  input  logic [1:0]    size_i,
  input  logic [AW-1:0] rn_i,
  input  logic [AW-1:0] r0_i,
  input  logic [AW-1:0] gbr_i,
  input  logic [AW-1:0] pc_i,
  input  logic [DW-1:0] disp_i,
  output logic          out_valid,
  output logic [AW-1:0] ea_o,
  output logic          mem_access_o,
  output logic          rn_wb_en_o,
  output logic [AW-1:0] rn_wb_val_o
);
  logic [AW-1:0] ea_c;
  logic          mem_c;
  logic          wb_en_c;
  logic [AW-1:0] wb_val_c;

  eagen_calc #(.AW(AW), .DW(DW), .D4_W(D4_W), .D8_W(D8_W)) u_calc (
    .mode_i   (mode_i),
    .size_i   (size_i),
    .rn_i     (rn_i),
    .r0_i     (r0_i),
    .gbr_i    (gbr_i),
    .pc_i     (pc_i),
    .disp_i   (disp_i),
    .ea_o     (ea_c),
    .mem_o    (mem_c),
    .wb_en_o  (wb_en_c),
    .wb_val_o (wb_val_c)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid    <= 1'b0;
      ea_o         <= '0;
      mem_access_o <= 1'b0;
      rn_wb_en_o   <= 1'b0;
      rn_wb_val_o  <= '0;
    end else begin
      out_valid    <= in_valid;
      mem_access_o <= in_valid & mem_c;
      rn_wb_en_o   <= in_valid & wb_en_c;
      if (in_valid) begin
        ea_o        <= ea_c;
        rn_wb_val_o <= wb_val_c;
      end
    end
  end
endmodule

// File: rtl/eagen_chk.sv
module eagen_chk #(
  parameter int AW = 32,
  parameter int DW = 12
) (
  input logic          clk,
  input logic          rst,
  input logic          in_valid,
  input logic [3:0]    mode_i,
  input logic [1:0]    size_i,
  input logic [AW-1:0] rn_i,
  input logic [AW-1:0] r0_i,
  input logic [AW-1:0] gbr_i,
  input logic          out_valid,
  input logic [AW-1:0] ea_o,
  input logic          mem_access_o,
  input logic          rn_wb_en_o,
  input logic [AW-1:0] rn_wb_val_o
);
  logic [AW-1:0] step_now;
  assign step_now = (size_i == 2'd0) ? AW'(1) : (size_i == 2'd1) ? AW'(2) : AW'(4);

  p_reset_clear_r1: assert property (@(posedge clk)
    $past(rst) |-> (!out_valid && !rn_wb_en_o && !mem_access_o && ea_o == '0));

  p_latency_r2: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (out_valid == $past(in_valid)));

  p_hold_r2: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(in_valid)) |-> ($stable(ea_o) && !rn_wb_en_o && !mem_access_o));

  p_ind_r3: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(in_valid) && $past(mode_i) == 4'd2) |-> (ea_o == $past(rn_i) && mem_access_o));

  p_postinc_r4: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(in_valid) && $past(mode_i) == 4'd3)
      |-> (ea_o == $past(rn_i) && rn_wb_val_o == $past(rn_i) + $past(step_now)));

  p_predec_r5: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(in_valid) && $past(mode_i) == 4'd4)
      |-> (ea_o == rn_wb_val_o && ea_o == $past(rn_i) - $past(step_now)));

  p_index_r7: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(in_valid) && $past(mode_i) == 4'd8) |-> (ea_o == $past(r0_i) + $past(gbr_i)));

  p_wb_only_auto_r11: assert property (@(posedge clk) disable iff (rst)
    rn_wb_en_o |-> (out_valid && ($past(mode_i) == 4'd3 || $past(mode_i) == 4'd4)));
endmodule

bind eagen_top eagen_chk #(.AW(AW), .DW(DW)) chk_i (
  .clk          (clk),
  .rst          (rst),
  .in_valid     (in_valid),
  .mode_i       (mode_i),
  .size_i       (size_i),
  .rn_i         (rn_i),
  .r0_i         (r0_i),
  .gbr_i        (gbr_i),
  .out_valid    (out_valid),
  .ea_o         (ea_o),
  .mem_access_o (mem_access_o),
  .rn_wb_en_o   (rn_wb_en_o),
  .rn_wb_val_o  (rn_wb_val_o)
);

// File: tb/eagen_top_tb_top.sv
module eagen_top_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [3:0]  mode_i = '0;
  logic [1:0]  size_i = '0;
  logic [31:0] rn_i = '0, r0_i = '0, gbr_i = '0, pc_i = '0;
  logic [11:0] disp_i = '0;
  logic        out_valid, mem_access_o, rn_wb_en_o;
  logic [31:0] ea_o, rn_wb_val_o;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  typedef struct {
    logic        v;
    logic        mem;
    logic        wb;
    logic [31:0] ea;
    logic [31:0] wbv;
    string       tag;
  } exp_t;

  exp_t exp_q[$];
  logic [31:0] held_ea = '0, held_wbv = '0;

  always #2.5 clk = ~clk;

  eagen_top dut_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .mode_i(mode_i), .size_i(size_i),
    .rn_i(rn_i), .r0_i(r0_i), .gbr_i(gbr_i), .pc_i(pc_i), .disp_i(disp_i),
    .out_valid(out_valid), .ea_o(ea_o), .mem_access_o(mem_access_o),
    .rn_wb_en_o(rn_wb_en_o), .rn_wb_val_o(rn_wb_val_o)
  );

  function automatic exp_t model(input logic v, input int md, input int sz,
                                 input logic [31:0] rn, input logic [31:0] r0,
                                 input logic [31:0] gbr, input logic [31:0] pc,
                                 input logic [11:0] d);
    exp_t e;
    longint step, mul, sd;
    step = (sz == 0) ? 1 : (sz == 1) ? 2 : 4;
    mul  = step;
    e.v = v; e.mem = 0; e.wb = 0; e.ea = 32'd0; e.wbv = rn; e.tag = "R11";
    if (!v) begin
      e.ea = held_ea; e.wbv = held_wbv; e.tag = "R2";
      return e;
    end
    case (md)
      2:  begin e.ea = rn; e.mem = 1; e.tag = "R3"; end
      3:  begin e.ea = rn; e.mem = 1; e.wb = 1; e.wbv = 32'(rn + step); e.tag = "R4"; end
      4:  begin e.ea = 32'(rn - step); e.wbv = e.ea; e.mem = 1; e.wb = 1; e.tag = "R5"; end
      5:  begin e.ea = 32'(rn + d[3:0] * mul); e.mem = 1; e.tag = "R6"; end
      6:  begin e.ea = 32'(r0 + rn); e.mem = 1; e.tag = "R7"; end
      7:  begin e.ea = 32'(gbr + d[7:0] * mul); e.mem = 1; e.tag = "R8"; end
      8:  begin e.ea = 32'(r0 + gbr); e.mem = 1; e.tag = "R7"; end
      9:  begin
            e.ea = 32'(((sz >= 2) ? (pc & 32'hFFFF_FFFC) : pc) + d[7:0] * mul);
            e.mem = 1; e.tag = "R9";
          end
      10: begin
            sd = (d >= 12'd2048) ? longint'(d) - 4096 : longint'(d);
            e.ea = 32'(longint'(pc) + sd * 2); e.tag = "R10";
          end
      default: begin e.ea = 32'd0; e.tag = "R11"; end
    endcase
    return e;
  endfunction

  task automatic check_out();
    exp_t e;
    if (exp_q.size() == 0) return;
    e = exp_q.pop_front();
    n_checks++;
    if (out_valid !== e.v || mem_access_o !== e.mem || rn_wb_en_o !== e.wb ||
        ea_o !== e.ea || rn_wb_val_o !== e.wbv) begin
      n_fail++;
      $display("FAIL %s: got v=%0b mem=%0b wb=%0b ea=%h wbv=%h, expected v=%0b mem=%0b wb=%0b ea=%h wbv=%h",
               e.tag, out_valid, mem_access_o, rn_wb_en_o, ea_o, rn_wb_val_o,
               e.v, e.mem, e.wb, e.ea, e.wbv);
    end
  endtask

  task automatic step(input logic v, input int md, input int sz,
                      input logic [31:0] rn, input logic [31:0] r0,
                      input logic [31:0] gbr, input logic [31:0] pc,
                      input logic [11:0] d);
    exp_t e;
    @(negedge clk);
    check_out();
    in_valid = v; mode_i = 4'(md); size_i = 2'(sz);
    rn_i = rn; r0_i = r0; gbr_i = gbr; pc_i = pc; disp_i = d;
    e = model(v, md, sz, rn, r0, gbr, pc, d);
    held_ea = e.ea; held_wbv = e.wbv;
    exp_q.push_back(e);
  endtask

  initial begin
    // R1: reset with a request present
    in_valid = 1'b1; mode_i = 4'd3; rn_i = 32'h1234_5678;
    @(posedge clk);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      n_checks++;
      if (out_valid !== 1'b0 || ea_o !== 32'd0 || mem_access_o !== 1'b0 ||
          rn_wb_en_o !== 1'b0 || rn_wb_val_o !== 32'd0) begin
        n_fail++;
        $display("FAIL R1: got v=%0b ea=%h mem=%0b wb=%0b wbv=%h, expected all zero",
                 out_valid, ea_o, mem_access_o, rn_wb_en_o, rn_wb_val_o);
      end
    end
    rst = 1'b0;
    in_valid = 1'b0;
    // Directed corners
    step(1, 2, 2, 32'hDEAD_BEEF, 0, 0, 0, 0);                    // R3
    step(1, 3, 0, 32'hFFFF_FFFF, 0, 0, 0, 0);                    // R4 wrap
    step(1, 3, 2, 32'h0000_1000, 0, 0, 0, 0);                    // R4 long
    step(0, 3, 2, 32'h5555_0000, 0, 0, 0, 0);                    // R2 idle
    step(1, 4, 2, 32'h0000_0000, 0, 0, 0, 0);                    // R5 wrap
    step(1, 4, 1, 32'h0000_0100, 0, 0, 0, 0);                    // R5 word
    step(1, 4, 0, 32'h0000_0000, 0, 0, 0, 0);                    // R5 byte wrap
    step(1, 5, 2, 32'h0000_2000, 0, 0, 0, 12'hFFF);              // R6 max disp
    step(1, 5, 0, 32'h0000_2000, 0, 0, 0, 12'h00F);              // R6 byte
    step(1, 6, 0, 32'h8000_0000, 32'h8000_0004, 0, 0, 0);        // R7
    step(1, 8, 0, 0, 32'h0000_0010, 32'hFFFF_FFF0, 0, 0);        // R7 gbr
    step(1, 7, 1, 0, 0, 32'h4000_0000, 0, 12'h0FF);              // R8
    for (int s = 0; s < 4; s++)
      step(1, 9, s, 0, 0, 0, 32'h0000_1003, 12'h0FF);            // R9 all sizes
    step(1, 10, 0, 0, 0, 0, 32'h0000_1000, 12'h800);             // R10 negative
    step(1, 10, 2, 0, 0, 0, 32'h0000_1000, 12'h7FF);             // R10 positive
    step(1, 0, 2, 32'h1111_1111, 0, 0, 0, 0);                    // R11 direct
    step(1, 1, 2, 32'h2222_2222, 0, 0, 0, 0);                    // R11 immediate
    step(1, 13, 2, 32'h3333_3333, 0, 0, 0, 0);                   // R11 reserved
    step(0, 0, 0, 0, 0, 0, 0, 0);                                // R2 idle
    // Mixed patterns
    for (int i = 0; i < 600; i++)
      step(($urandom % 5) != 0, int'($urandom % 16), int'($urandom % 4),
           $urandom, $urandom, $urandom, $urandom, 12'($urandom));
    step(0, 0, 0, 0, 0, 0, 0, 0);
    @(negedge clk);
    check_out();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    #(200000 * 5.0);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: got no completion, expected run to finish");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end
endmodule